// File: doc/BRIEF.md
# Software Trace Event Capture Unit

This unit sits beside a processor core and turns instrumented software into trace events. Software first places a value in the first argument register (register index 10), then writes an identifier to a dedicated trace CSR. The unit keeps the most recent value written back to register 10. When the trigger CSR write arrives, it forms one event from the 16-bit identifier and that stored value, as a single indivisible action.

A second event source is a change comparator on one user register chosen through configuration. The comparator is a small state machine with three states. `W_IDLE` means the comparator is disabled. `W_BASE` means it is enabled but has not yet seen a baseline value. `W_ARMED` means a baseline is held. The transitions are: `W_IDLE` to `W_BASE` when it is enabled; `W_IDLE` or `W_BASE` to `W_ARMED` on a write to the watched register while enabled; any state to `W_IDLE` when the enable drops. In `W_ARMED`, a write to the watched register whose data differs from the baseline emits an event with the reserved identifier 0xFFFF.

Events from both sources enter a four-entry queue and leave on a valid/ready handshake toward a packetizer. A stall input mutes the unit: triggers that arrive while it is high are discarded. Register tracking continues during a stall.

Top module: `swtrace_capture`

## Requirements
- R1: A CSR write to address 0x8FF queues one event. Its id is write data bits [15:0] and its value is the stored register-10 contents. `ev_valid` goes high in the cycle after the write when the queue was empty.
- R2: Each writeback to register 10 replaces the stored value, and the last write wins. Writebacks to any other register leave the stored value unchanged.
- R3: When a register-10 writeback and the trigger CSR write happen in the same cycle, the event carries the newly written data.
- R4: CSR writes to any address other than 0x8FF queue nothing.
- R5: With the comparator in `W_ARMED`, a write to the watched register with data different from the baseline queues an event with id 0xFFFF and the new data as its value. A write of equal data queues nothing.
- R6: After the comparator is enabled, the first write to the watched register only records the baseline and emits nothing. Dropping the enable returns the comparator to `W_IDLE`, so the baseline is forgotten.
- R7: When a CSR trigger and a comparator event happen in the same cycle, the CSR event is queued first and the comparator event second.
- R8: While `stall` is high, no event is queued. Register-10 tracking and the comparator baseline still update during the stall.
- R9: The queue holds four events. An event that finds no free slot is dropped and sets `ovf_flag`. The flag stays set until `cfg_ovf_clear` is pulsed, and a drop in the same cycle as a clear wins.
- R10: Events leave in queue order on valid/ready. `ev_id` and `ev_value` stay stable while `ev_valid` is high and `ev_ready` is low.
- R11: After reset, `ev_valid` and `ovf_flag` are low, the stored register-10 value is zero and the comparator is in `W_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Core register writeback strobe |
| wb_reg | input | 5 | Writeback destination register index |
| wb_data | input | XLEN | Writeback data |
| csr_we | input | 1 | Core CSR write strobe |
| csr_addr | input | 12 | CSR write address |
| csr_wdata | input | XLEN | CSR write data; bits [15:0] form the event id |
| cfg_watch_en | input | 1 | Comparator enable |
| cfg_watch_reg | input | 5 | Index of the register the comparator watches |
| cfg_ovf_clear | input | 1 | Clears the overflow flag |
| stall | input | 1 | Mutes event generation while high |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_id | output | 16 | Event identifier |
| ev_value | output | XLEN | Event value |
| ovf_flag | output | 1 | Sticky flag for a dropped event |

## Verification
A stale register-10 copy or a missing same-cycle bypass shows at the ports as a wrong `ev_value` in the cycle after the trigger. A comparator left in the wrong state shows as a spurious or missing 0xFFFF event on the first or second watched write. Queue pointer or count faults show as reordered, repeated or lost events within four pops. They also show as an `ovf_flag` that rises early or late relative to the fifth unread event.

// File: rtl/swtrace_pkg.sv
package swtrace_pkg;
    localparam int ID_W        = 16;
    localparam int RIDX_W      = 5;
    localparam int CSR_AW      = 12;
    localparam logic [ID_W-1:0] CMP_EVENT_ID = 16'hFFFF;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_BASE  = 2'd1,
        W_ARMED = 2'd2
    } watch_state_e;
endpackage

// File: rtl/swtrace_watch.sv
module swtrace_watch
    import swtrace_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RIDX_W-1:0] watch_reg,
    input  logic              wb_valid,
    input  logic [RIDX_W-1:0] wb_reg,
    input  logic [XLEN-1:0]   wb_data,
    output logic              fire,
    output logic [XLEN-1:0]   fire_value
);
    watch_state_e state_q, state_d;
    logic [XLEN-1:0] base_q;
    logic hit;

    assign hit = en && wb_valid && (wb_reg == watch_reg);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:  if (en) state_d = hit ? W_ARMED : W_BASE;
            W_BASE:  if (!en) state_d = W_IDLE; else if (hit) state_d = W_ARMED;
            W_ARMED: if (!en) state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (hit) base_q <= wb_data;
        end
    end

    always_comb begin
        fire       = 1'b0;
        fire_value = wb_data;
        unique case (state_q)
            W_ARMED: fire = hit && (wb_data != base_q);
            default: fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/swtrace_evq.sv
module swtrace_evq #(
    parameter int W     = 80,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_a,
    input  logic [W-1:0] data_a,
    input  logic         push_b,
    input  logic [W-1:0] data_b,
    output logic         drop,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count, space;
    logic acc_a, acc_b, pop;

    assign space     = CW'(DEPTH) - count;
    assign acc_a     = push_a && (space >= CW'(1));
    assign acc_b     = push_b && (space >= (acc_a ? CW'(2) : CW'(1)));
    assign drop      = (push_a && !acc_a) || (push_b && !acc_b);
    assign out_valid = (count != '0);
    assign pop       = out_valid && out_ready;
    assign out_data  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (acc_a) mem[wr_ptr] <= data_a;
        if (acc_b) mem[wr_ptr + PW'(acc_a)] <= data_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(acc_a) + PW'(acc_b);
            rd_ptr <= rd_ptr + PW'(pop);
            count  <= count + CW'(acc_a) + CW'(acc_b) - CW'(pop);
        end
    end
endmodule

// File: rtl/swtrace_capture.sv
module swtrace_capture
    import swtrace_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int QDEPTH     = 4,
    parameter int ARG_REG    = 10,
    parameter int TRIG_CSR   = 12'h8FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_valid,
    input  logic [RIDX_W-1:0] wb_reg,
    input  logic [XLEN-1:0]   wb_data,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              cfg_watch_en,
    input  logic [RIDX_W-1:0] cfg_watch_reg,
    input  logic              cfg_ovf_clear,
    input  logic              stall,
    output logic              ev_valid,
    input  logic              ev_ready,
    output logic [ID_W-1:0]   ev_id,
    output logic [XLEN-1:0]   ev_value,
    output logic              ovf_flag
);
    localparam int EW = ID_W + XLEN;

    logic [XLEN-1:0] arg_q, arg_now;
    logic            arg_wr, trig, cmp_fire, drop;
    logic [XLEN-1:0] cmp_value;
    logic [EW-1:0]   head;
    logic            unused_hi;

    assign unused_hi = ^csr_wdata[XLEN-1:ID_W];
    assign arg_wr    = wb_valid && (wb_reg == RIDX_W'(ARG_REG));
    assign arg_now   = arg_wr ? wb_data : arg_q;
    assign trig      = csr_we && (csr_addr == CSR_AW'(TRIG_CSR));

    always_ff @(posedge clk) begin
        if (!rst_n)      arg_q <= '0;
        else if (arg_wr) arg_q <= wb_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)             ovf_flag <= 1'b0;
        else if (drop)          ovf_flag <= 1'b1;
        else if (cfg_ovf_clear) ovf_flag <= 1'b0;
    end

    swtrace_watch #(.XLEN(XLEN)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_watch_en),
        .watch_reg  (cfg_watch_reg),
        .wb_valid   (wb_valid),
        .wb_reg     (wb_reg),
        .wb_data    (wb_data),
        .fire       (cmp_fire),
        .fire_value (cmp_value)
    );

    swtrace_evq #(.W(EW), .DEPTH(QDEPTH)) u_evq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_a    (trig && !stall),
        .data_a    ({csr_wdata[ID_W-1:0], arg_now}),
        .push_b    (cmp_fire && !stall),
        .data_b    ({CMP_EVENT_ID, cmp_value}),
        .drop      (drop),
        .out_valid (ev_valid),
        .out_ready (ev_ready),
        .out_data  (head)
    );

    assign ev_id    = head[EW-1:XLEN];
    assign ev_value = head[XLEN-1:0];
endmodule

// File: rtl/swtrace_capture_checker.sv
module swtrace_capture_checker
    import swtrace_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int TRIG_CSR = 12'h8FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_we,
    input logic [CSR_AW-1:0] csr_addr,
    input logic [ID_W-1:0]   trig_id,
    input logic              wb_valid,
    input logic [RIDX_W-1:0] wb_reg,
    input logic              cfg_watch_en,
    input logic [RIDX_W-1:0] cfg_watch_reg,
    input logic              cfg_ovf_clear,
    input logic              stall,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [ID_W-1:0]   ev_id,
    input logic [XLEN-1:0]   ev_value,
    input logic              ovf_flag
);
    logic is_trig, may_cmp;
    assign is_trig = csr_we && (csr_addr == CSR_AW'(TRIG_CSR));
    assign may_cmp = cfg_watch_en && wb_valid && (wb_reg == cfg_watch_reg);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_id) && $stable(ev_value));

    a_r1_trigger_queues: assert property (@(posedge clk) disable iff (!rst_n)
        is_trig && !stall && !ev_valid |=> ev_valid && (ev_id == $past(trig_id)));

    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid && !is_trig && !may_cmp |=> !ev_valid);

    a_r8_stall_mutes: assert property (@(posedge clk) disable iff (!rst_n)
        stall && !ev_valid |=> !ev_valid);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !cfg_ovf_clear |=> ovf_flag);
endmodule

bind swtrace_capture swtrace_capture_checker #(.XLEN(XLEN), .TRIG_CSR(TRIG_CSR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_we        (csr_we),
    .csr_addr      (csr_addr),
    .trig_id       (csr_wdata[15:0]),
    .wb_valid      (wb_valid),
    .wb_reg        (wb_reg),
    .cfg_watch_en  (cfg_watch_en),
    .cfg_watch_reg (cfg_watch_reg),
    .cfg_ovf_clear (cfg_ovf_clear),
    .stall         (stall),
    .ev_valid      (ev_valid),
    .ev_ready      (ev_ready),
    .ev_id         (ev_id),
    .ev_value      (ev_value),
    .ovf_flag      (ovf_flag)
);

// File: tb/swtrace_capture_bench.sv
module swtrace_capture_bench;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wb_valid = 1'b0;
    logic [4:0]      wb_reg = '0;
    logic [XLEN-1:0] wb_data = '0;
    logic            csr_we = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            cfg_watch_en = 1'b0;
    logic [4:0]      cfg_watch_reg = '0;
    logic            cfg_ovf_clear = 1'b0;
    logic            stall = 1'b0;
    logic            ev_valid;
    logic            ev_ready = 1'b0;
    logic [15:0]     ev_id;
    logic [XLEN-1:0] ev_value;
    logic            ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    swtrace_capture u_swtrace_capture (.*);

    task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] r, input logic [XLEN-1:0] d);
        @(negedge clk); wb_valid = 1'b1; wb_reg = r; wb_data = d;
        @(negedge clk); wb_valid = 1'b0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [15:0] id);
        @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = {48'hDEAD_BEEF_0BAD, id};
        @(negedge clk); csr_we = 1'b0;
    endtask

    task automatic pop(input logic [15:0] id, input logic [XLEN-1:0] v, input string tag);
        chk(ev_valid && ev_id == id && ev_value == v, tag, {15'd0, ev_valid, ev_id, ev_value}, {15'd0, 1'b1, id, v});
        ev_ready = 1'b1;
        @(negedge clk); ev_ready = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        chk(!ev_valid, tag, {79'd0, ev_valid}, 80'd0);
    endtask

    task automatic t_reset;
        chk(!ev_valid && !ovf_flag, "R11 reset outputs", {78'd0, ev_valid, ovf_flag}, 80'd0);
        csr_wr(12'h8FF, 16'h0001);
        pop(16'h0001, 64'd0, "R11 stored value zero after reset");
    endtask

    task automatic t_basic;
        wr_reg(5'd10, 64'h1111_2222_3333_4444);
        csr_wr(12'h8FF, 16'h1234);
        pop(16'h1234, 64'h1111_2222_3333_4444, "R1 basic event");
        wr_reg(5'd10, 64'hA);
        wr_reg(5'd10, 64'hB);
        wr_reg(5'd11, 64'hC);
        csr_wr(12'h8FF, 16'h0042);
        pop(16'h0042, 64'hB, "R2 last a0 write wins, other reg ignored");
        expect_empty("R1 single event per trigger");
    endtask

    task automatic t_bypass;
        @(negedge clk);
        wb_valid = 1'b1; wb_reg = 5'd10; wb_data = 64'h77;
        csr_we = 1'b1; csr_addr = 12'h8FF; csr_wdata = 64'h00BE;
        @(negedge clk); wb_valid = 1'b0; csr_we = 1'b0;
        pop(16'h00BE, 64'h77, "R3 same-cycle bypass");
    endtask

    task automatic t_other_csr;
        csr_wr(12'h8FE, 16'h0005);
        expect_empty("R4 other csr 0x8FE");
        csr_wr(12'h0FF, 16'h0006);
        expect_empty("R4 other csr 0x0FF");
    endtask

    task automatic t_watch;
        @(negedge clk); cfg_watch_en = 1'b1; cfg_watch_reg = 5'd2;
        wr_reg(5'd2, 64'd5);
        expect_empty("R6 baseline write silent");
        wr_reg(5'd2, 64'd5);
        expect_empty("R5 equal value silent");
        wr_reg(5'd2, 64'd7);
        pop(16'hFFFF, 64'd7, "R5 change event");
        @(negedge clk); cfg_watch_en = 1'b0;
        @(negedge clk); cfg_watch_en = 1'b1;
        wr_reg(5'd2, 64'd9);
        expect_empty("R6 re-enable needs new baseline");
        @(negedge clk); cfg_watch_en = 1'b0;
    endtask

    task automatic t_order;
        @(negedge clk); cfg_watch_en = 1'b1; cfg_watch_reg = 5'd10;
        wr_reg(5'd10, 64'd1);
        expect_empty("R6 baseline on a0");
        @(negedge clk);
        wb_valid = 1'b1; wb_reg = 5'd10; wb_data = 64'd2;
        csr_we = 1'b1; csr_addr = 12'h8FF; csr_wdata = 64'h0055;
        @(negedge clk); wb_valid = 1'b0; csr_we = 1'b0;
        pop(16'h0055, 64'd2, "R7 csr event first");
        pop(16'hFFFF, 64'd2, "R7 compare event second");
        @(negedge clk); cfg_watch_en = 1'b0;
    endtask

    task automatic t_stall;
        @(negedge clk); stall = 1'b1;
        csr_wr(12'h8FF, 16'h0009);
        wr_reg(5'd10, 64'hAB);
        expect_empty("R8 stalled trigger dropped");
        @(negedge clk); stall = 1'b0;
        csr_wr(12'h8FF, 16'h0003);
        pop(16'h0003, 64'hAB, "R8 a0 tracked during stall");
        chk(!ovf_flag, "R8 stall not overflow", {79'd0, ovf_flag}, 80'd0);
    endtask

    task automatic t_overflow;
        wr_reg(5'd10, 64'h5A);
        for (int i = 0; i < 5; i++) csr_wr(12'h8FF, 16'(i));
        chk(ovf_flag, "R9 overflow set on fifth", {79'd0, ovf_flag}, 80'd1);
        repeat (2) @(negedge clk);
        chk(ev_id == 16'd0 && ev_valid, "R10 head stable while not ready", {63'd0, ev_valid, ev_id}, {63'd0, 1'b1, 16'd0});
        for (int i = 0; i < 4; i++) pop(16'(i), 64'h5A, "R10 in-order drain");
        expect_empty("R9 fifth event dropped");
        chk(ovf_flag, "R9 overflow sticky", {79'd0, ovf_flag}, 80'd1);
        @(negedge clk); cfg_ovf_clear = 1'b1;
        @(negedge clk); cfg_ovf_clear = 1'b0;
        chk(!ovf_flag, "R9 overflow cleared", {79'd0, ovf_flag}, 80'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_bypass();
        t_other_csr();
        t_watch();
        t_order();
        t_stall();
        t_overflow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule